// File: doc/BRIEF.md
# Multi-Channel PWM Controller

The block is a bank of pulse-width modulators that sit behind a small synchronous register bus. Each channel has its own counter, duty and period registers and its own selectable count source. A channel runs only while its enable bit is set. The enable bits are changed through two separate write-one registers: one sets bits and the other clears them. At every period boundary a channel flags a pending event. Software sees the pending events in a status register that clears itself when read. It selects which pending events drive the single combined interrupt line through a mask, and the mask is changed through a write-one set/clear pair.

Clock division is done elsewhere. The block receives two tick strobes, and each channel picks either the raw clock or one of the two strobes as its count source. A channel counts in one of two ways. In left-aligned mode it counts up and wraps. In center-aligned mode it counts up and then down, which takes twice as long for the same period value.

Top module: `pwm_multi`

## Requirements
- R1: After reset all channels are disabled, the interrupt mask and the pending bits are zero, `irq` is low, `rdata` is zero and every `pwm_out` bit is low.
- R2: Writing to 0x04 sets enable bit n for every 1 in `wdata` bit n. Writing to 0x08 clears enable bit n for every 1 in `wdata` bit n. A 0 bit has no effect. A read of 0x0C returns the enable bits in bits [NCH-1:0].
- R3: Writing to 0x10 sets mask bits and writing to 0x14 clears mask bits, with the same write-one rule as R2. A read of 0x18 returns the mask.
- R4: A read of 0x1C returns the pending bits and clears them at the same edge. An event raised in the same cycle as the read stays pending.
- R5: `irq` is high exactly while some pending bit is also set in the mask.
- R6: In left-aligned mode (mode bit 8 = 0) with period P ≥ 1, the counter steps through 0, 1, …, P-1 on successive ticks and then returns to 0. The pending bit is set at the edge where the counter returns to 0.
- R7: In center-aligned mode (mode bit 8 = 1) with period P ≥ 1, the counter steps 0, 1, …, P, P-1, …, 1 and then returns to 0, which gives a repeat of 2P ticks. The pending bit is set at the edge where the counter returns to 0.
- R8: `pwm_out[n]` is active while channel n is enabled and its counter is below its duty value. Mode bit 9 inverts the output, so active is high when bit 9 = 0 and low when bit 9 = 1. A disabled channel drives the inactive level and its counter reads 0.
- R9: Mode bits [3:0] select the count source. 0 advances the counter every clock, 1 advances it on `tick_a`, 2 advances it on `tick_b`, and any other value never advances it.
- R10: The counter register is read-only. A write to it leaves the count unchanged.
- R11: Channel n's bank starts at 0x200 + n·0x20. Within the bank, offset 0x0 holds the mode (bits [3:0], 8 and 9 read back), 0x4 the duty, 0x8 the period and 0xC the counter. `rdata` carries the read value in the cycle after `rd` and is 0 otherwise. Unmapped addresses read 0.
- R12: With period 0 an enabled channel's counter stays at 0 and it raises no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_a | input | 1 | First count strobe |
| tick_b | input | 1 | Second count strobe |
| addr | input | AW (12) | Byte address of the register access |
| wdata | input | DW (32) | Write data |
| wr | input | 1 | Write strobe, one cycle per access |
| rd | input | 1 | Read strobe, one cycle per access |
| rdata | output | DW (32) | Read data, valid the cycle after `rd` |
| pwm_out | output | NCH (4) | Per-channel PWM outputs |
| irq | output | 1 | Combined masked interrupt |

## Verification
A write takes effect at the edge on which `wr` is sampled. A read issued in the next cycle therefore already sees the new value, and `rdata` shows it one edge after `rd`. A channel enabled at edge E holds 0 at E and then gains one count per tick. A read sampled at edge R therefore returns the state after R-1-E ticks, and the bench expectation functions use exactly that count. `pwm_out` and `irq` are decoded from registers without further delay. The bench samples them at the falling edge after the edge that moved the counter or set the pending bit. All bus signals are driven at falling edges, so every result is read half a cycle after the edge that produced it.

// File: rtl/pwm_multi.sv
`timescale 1ns/1ps
module pwm_multi #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int AW  = 12,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_a,
  input  logic          tick_b,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  output logic [NCH-1:0] pwm_out,
  output logic          irq
);
  localparam logic [AW-1:0] A_ENA = AW'('h04);
  localparam logic [AW-1:0] A_DIS = AW'('h08);
  localparam logic [AW-1:0] A_STA = AW'('h0C);
  localparam logic [AW-1:0] A_IEN = AW'('h10);
  localparam logic [AW-1:0] A_IDS = AW'('h14);
  localparam logic [AW-1:0] A_MSK = AW'('h18);
  localparam logic [AW-1:0] A_ISR = AW'('h1C);
  localparam logic [AW-1:0] A_CH0 = AW'('h200);
  localparam logic [AW-6:0] NCH_L = (AW-5)'(NCH);

  logic [NCH-1:0] en_q, msk_q, isr_q, evt;
  logic [NCH-1:0][DW-1:0] chrd;
  logic [DW-1:0]  rd_val;

  wire [AW-1:0] off    = addr - A_CH0;
  wire          ch_hit = (addr >= A_CH0) && (off[AW-1:5] < NCH_L) && (off[1:0] == 2'b00);
  wire [4:0]    ci     = off[9:5];
  wire [2:0]    rsel   = off[4:2];
  wire          isr_rd = rd && (addr == A_ISR);

  wire [NCH-1:0] en_set  = (wr && addr == A_ENA) ? wdata[NCH-1:0] : '0;
  wire [NCH-1:0] en_clr  = (wr && addr == A_DIS) ? wdata[NCH-1:0] : '0;
  wire [NCH-1:0] msk_set = (wr && addr == A_IEN) ? wdata[NCH-1:0] : '0;
  wire [NCH-1:0] msk_clr = (wr && addr == A_IDS) ? wdata[NCH-1:0] : '0;

  assign irq = |(isr_q & msk_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      msk_q <= '0;
      isr_q <= '0;
      rdata <= '0;
    end else begin
      en_q  <= (en_q | en_set) & ~en_clr;
      msk_q <= (msk_q | msk_set) & ~msk_clr;
      isr_q <= (isr_q & ~{NCH{isr_rd}}) | evt;
      rdata <= rd ? rd_val : '0;
    end
  end

  always_comb begin
    rd_val = '0;
    case (addr)
      A_STA: rd_val[NCH-1:0] = en_q;
      A_MSK: rd_val[NCH-1:0] = msk_q;
      A_ISR: rd_val[NCH-1:0] = isr_q;
      default: begin
        for (int k = 0; k < NCH; k++)
          if (ch_hit && ci == 5'(k)) rd_val = chrd[k];
      end
    endcase
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0] cnt, duty, per;
    logic [3:0]    src;
    logic          ctr, pol, down, tk;

    wire sel = wr && ch_hit && (ci == 5'(i));

    always_comb begin
      case (src)
        4'd0:    tk = 1'b1;
        4'd1:    tk = tick_a;
        4'd2:    tk = tick_b;
        default: tk = 1'b0;
      endcase
    end

    assign evt[i] = en_q[i] && tk && (per != '0) &&
                    (ctr ? (cnt == CW'(1) && (down || cnt >= per))
                         : (cnt >= per - CW'(1)));

    assign pwm_out[i] = (en_q[i] && cnt < duty) ^ pol;

    always_comb begin
      chrd[i] = '0;
      case (rsel)
        3'd0: begin
          chrd[i][3:0] = src;
          chrd[i][8]   = ctr;
          chrd[i][9]   = pol;
        end
        3'd1: chrd[i][CW-1:0] = duty;
        3'd2: chrd[i][CW-1:0] = per;
        3'd3: chrd[i][CW-1:0] = cnt;
        default: ;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt  <= '0;
        duty <= '0;
        per  <= '0;
        src  <= '0;
        ctr  <= 1'b0;
        pol  <= 1'b0;
        down <= 1'b0;
      end else begin
        if (sel) begin
          case (rsel)
            3'd0: begin
              src <= wdata[3:0];
              ctr <= wdata[8];
              pol <= wdata[9];
            end
            3'd1: duty <= wdata[CW-1:0];
            3'd2: per  <= wdata[CW-1:0];
            default: ;
          endcase
        end
        if (!en_q[i]) begin
          cnt  <= '0;
          down <= 1'b0;
        end else if (tk && per != '0) begin
          if (!ctr) begin
            down <= 1'b0;
            cnt  <= (cnt >= per - CW'(1)) ? '0 : cnt + CW'(1);
          end else if (!down && cnt < per) begin
            cnt <= cnt + CW'(1);
          end else if (cnt <= CW'(1)) begin
            cnt  <= '0;
            down <= 1'b0;
          end else begin
            cnt  <= cnt - CW'(1);
            down <= 1'b1;
          end
        end
      end
    end

    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == A_ENA && wdata[i]) |=> en_q[i]);
    // R3
    msk_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == A_IDS && wdata[i]) |=> !msk_q[i]);
    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[i] |=> cnt == '0);
    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && !ctr && per != '0 && cnt < per) |=> (cnt < per || !$stable(per) || ctr));
    // R12
    zero_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (per == '0) |-> !evt[i]);
  end

  // R4
  isr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isr_rd |=> (isr_q & ~$past(evt)) == '0);
  // R11
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> rdata == '0);
endmodule

// File: tb/pwm_multi_test.sv
`timescale 1ns/1ps
module pwm_multi_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_a = 1'b0, tick_b = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] rdata;
  logic [3:0]  pwm_out;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  pwm_multi uut (
    .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
    .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata), .pwm_out(pwm_out), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [11:0] cb(input int ch, input int r);
    return 12'(32'h200 + ch * 32 + r);
  endfunction

  function automatic int exp_cnt(input bit center, input int p, input int t);
    int v;
    if (p == 0) return 0;
    if (!center) return t % p;
    v = t % (2 * p);
    return (v <= p) ? v : 2 * p - v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata", rdata, 0);
    chk("R1 pwm_out", {28'd0, pwm_out}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    rd_reg(12'h00C, v); chk("R1 enables", v, 0);
    rd_reg(12'h018, v); chk("R1 mask", v, 0);
    rd_reg(12'h01C, v); chk("R1 pending", v, 0);

    // R2 set/clear enables
    wr_reg(12'h004, 32'h5);   rd_reg(12'h00C, v); chk("R2 set", v, 32'h5);
    wr_reg(12'h004, 32'h0);   rd_reg(12'h00C, v); chk("R2 zero set", v, 32'h5);
    wr_reg(12'h008, 32'h0);   rd_reg(12'h00C, v); chk("R2 zero clr", v, 32'h5);
    wr_reg(12'h008, 32'h1);   rd_reg(12'h00C, v); chk("R2 clr", v, 32'h4);
    wr_reg(12'h008, 32'hF);   rd_reg(12'h00C, v); chk("R2 clr all", v, 32'h0);

    // R3 mask
    wr_reg(12'h010, 32'hA);   rd_reg(12'h018, v); chk("R3 set", v, 32'hA);
    wr_reg(12'h014, 32'h2);   rd_reg(12'h018, v); chk("R3 clr", v, 32'h8);
    wr_reg(12'h014, 32'h0);   rd_reg(12'h018, v); chk("R3 zero", v, 32'h8);
    wr_reg(12'h014, 32'hF);   rd_reg(12'h018, v); chk("R3 clr all", v, 32'h0);

    // R11 bank layout and unmapped reads
    wr_reg(cb(2, 0), 32'hFFFF_FFFF); rd_reg(cb(2, 0), v); chk("R11 mode", v, 32'h30F);
    wr_reg(cb(2, 0), 32'h0);
    wr_reg(cb(2, 4), 32'h1234_ABCD); rd_reg(cb(2, 4), v); chk("R11 duty", v, 32'hABCD);
    wr_reg(cb(3, 8), 32'h0000_0777); rd_reg(cb(3, 8), v); chk("R11 period", v, 32'h777);
    rd_reg(cb(2, 8), v); chk("R11 other bank", v, 0);
    rd_reg(12'h100, v);  chk("R11 unmapped", v, 0);
    rd_reg(cb(4, 4), v); chk("R11 past banks", v, 0);

    // R8 / R6 left-aligned output, ch0 P=10 duty=3
    wr_reg(cb(0, 8), 32'd10);
    wr_reg(cb(0, 4), 32'd3);
    wr_reg(cb(0, 0), 32'h0);
    wr_reg(12'h004, 32'h1);
    for (int j = 0; j < 25; j++) begin
      chk("R8 left out", {31'd0, pwm_out[0]}, {31'd0, ((j % 10) < 3)});
      @(negedge clk);
    end
    wr_reg(12'h008, 32'h1);
    chk("R8 disabled low", {31'd0, pwm_out[0]}, 0);
    wr_reg(cb(0, 0), 32'h200);
    chk("R8 disabled inv", {31'd0, pwm_out[0]}, 1);
    rd_reg(cb(0, 12), v); chk("R8 idle cnt", v, 0);
    wr_reg(12'h004, 32'h1);
    for (int j = 0; j < 12; j++) begin
      chk("R8 inverted", {31'd0, pwm_out[0]}, {31'd0, !((j % 10) < 3)});
      @(negedge clk);
    end
    wr_reg(12'h008, 32'h1);
    wr_reg(cb(0, 0), 32'h0);

    // R7 center-aligned, ch1 P=4 duty=2
    wr_reg(cb(1, 8), 32'd4);
    wr_reg(cb(1, 4), 32'd2);
    wr_reg(cb(1, 0), 32'h100);
    wr_reg(12'h004, 32'h2);
    for (int j = 0; j < 20; j++) begin
      chk("R7 center out", {31'd0, pwm_out[1]}, {31'd0, (exp_cnt(1, 4, j) < 2)});
      @(negedge clk);
    end
    wr_reg(12'h008, 32'h2);

    // R4 / R5 / R6 event timing, ch0 P=5
    rd_reg(12'h01C, v);
    wr_reg(cb(0, 8), 32'd5);
    wr_reg(12'h010, 32'h1);
    wr_reg(12'h004, 32'h1);
    for (int j = 0; j < 6; j++) begin
      chk("R5 irq timing", {31'd0, irq}, {31'd0, (j == 5)});
      if (j < 5) @(negedge clk);
    end
    rd_reg(12'h01C, v);
    chk("R4 pending read", v, 32'h1);
    chk("R5 irq after clear", {31'd0, irq}, 0);
    wr_reg(12'h008, 32'h1);
    rd_reg(12'h01C, v);
    rd_reg(12'h01C, v); chk("R4 cleared", v, 0);
    wr_reg(12'h004, 32'h1);
    idle(12);
    wr_reg(12'h008, 32'h1);
    wr_reg(12'h014, 32'h1);
    chk("R5 masked off", {31'd0, irq}, 0);
    rd_reg(12'h01C, v); chk("R6 pending while unmasked off", v, 32'h1);

    // R9 count source
    wr_reg(cb(3, 8), 32'd100);
    wr_reg(cb(3, 0), 32'h1);
    tick_a = 1'b0; tick_b = 1'b1;
    wr_reg(12'h004, 32'h8);
    idle(9);
    rd_reg(cb(3, 12), v); chk("R9 tick_a low", v, 0);
    wr_reg(12'h008, 32'h8);
    tick_a = 1'b1;
    wr_reg(12'h004, 32'h8);
    idle(7);
    rd_reg(cb(3, 12), v); chk("R9 tick_a high", v, 8);
    wr_reg(12'h008, 32'h8);
    tick_a = 1'b0;
    wr_reg(cb(3, 0), 32'h2);
    wr_reg(12'h004, 32'h8);
    idle(4);
    rd_reg(cb(3, 12), v); chk("R9 tick_b", v, 5);
    wr_reg(12'h008, 32'h8);
    wr_reg(cb(3, 0), 32'h3);
    wr_reg(12'h004, 32'h8);
    idle(6);
    rd_reg(cb(3, 12), v); chk("R9 unused source", v, 0);
    wr_reg(12'h008, 32'h8);
    tick_b = 1'b0;

    // R10 counter write ignored
    wr_reg(cb(2, 8), 32'd100);
    wr_reg(cb(2, 0), 32'h0);
    wr_reg(12'h004, 32'h4);
    idle(3);
    wr_reg(cb(2, 12), 32'd77);
    rd_reg(cb(2, 12), v); chk("R10 read-only", v, 6);
    wr_reg(12'h008, 32'h4);

    // R12 period zero
    wr_reg(cb(2, 8), 32'd0);
    rd_reg(12'h01C, v);
    wr_reg(12'h004, 32'h4);
    idle(10);
    rd_reg(cb(2, 12), v); chk("R12 hold", v, 0);
    rd_reg(12'h01C, v); chk("R12 no event", v, 0);
    wr_reg(12'h008, 32'h4);

    // R6 / R7 random configurations
    for (int it = 0; it < 24; it++) begin
      int ch, p, n;
      bit c;
      ch = int'($urandom % 4);
      c  = 1'($urandom % 2);
      p  = 1 + int'($urandom % 20);
      n  = int'($urandom % 60);
      wr_reg(cb(ch, 8), 32'(p));
      wr_reg(cb(ch, 0), c ? 32'h100 : 32'h0);
      wr_reg(12'h004, 32'(1 << ch));
      idle(n);
      rd_reg(cb(ch, 12), v);
      chk(c ? "R7 random count" : "R6 random count", v, 32'(exp_cnt(c, p, n + 1)));
      wr_reg(12'h008, 32'(1 << ch));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule